// File: doc/BRIEF.md
# Indirect CSR Access Permission Checker

This block sits beside the CSR decode stage of a processor that offers indirect register access. That access works through select registers, which hold an index, and through data-window registers, which alias whatever target the index names. The block checks one CSR request at a time that touches a select register or a window. It decides whether the access may go ahead. If it may not, it decides whether the core must raise an illegal-instruction trap or a virtual-instruction trap.

The decision uses four groups of inputs:
- the address class in CSR address bits [9:8];
- the current privilege level and the virtualization flag;
- the two indirect-access enable bits that the core takes from bit 60 of its machine-level and hypervisor-level state-enable words;
- a tie-off that says whether state-enable control exists, and a flag from the window logic that says whether the current select value names a target that is implemented.

Once per request the block registers a one-hot verdict. The checks run in a fixed order, and the first rule that fails decides the outcome:
1. the reserved privilege level;
2. the machine enable;
3. the hypervisor enable;
4. the virtualization rules;
5. the missing target;
6. the ordinary rule that a CSR's class must not be above the current privilege level.

The data path and the target register file are outside this block.

Top module: `csrind_perm_check`

## Requirements
- R1: After reset, and in any cycle that follows a cycle without req_valid, allow, trap_illegal and trap_virtual are all 0.
- R2: A request sampled with req_valid high gives a verdict one clock later, and exactly one of allow, trap_illegal and trap_virtual is 1. Privilege is encoded U=0, S=1, M=3.
- R3: If stateen_present=1, privilege is below M, the class (address bits [9:8]) is below 3 and m_ind_en=0, the verdict is trap_illegal. This takes precedence over every virtualization rule.
- R4: If R3 does not trap, stateen_present=1, virt=1, the class is below 3 and h_ind_en=0, the verdict is trap_virtual.
- R5: With virt=1 and privilege below M, an access whose class is 2 (the virtual-supervisor copies) gives trap_virtual unless an earlier rule traps.
- R6: With virt=1 and privilege U, an access to a class-0 or class-1 register gives trap_virtual unless an earlier rule traps.
- R7: An address is a select register when its bits other than [9:8] equal 0x050. Every other address is a data window. A window access with tgt_present=0 gives trap_illegal, even with virt=1, unless an earlier rule traps. tgt_present has no effect on select accesses.
- R8: Class-3 registers skip R3 to R6. From privilege M with tgt_present=1 they are allowed whatever the enable bits are. From privilege below M they give trap_illegal.
- R9: In privilege M, virt, m_ind_en and h_ind_en have no effect.
- R10: With stateen_present=0, m_ind_en and h_ind_en have no effect.
- R11: If no earlier rule traps, the access gives trap_illegal when the current privilege is below the class's required level. The required level is the class value, except for class 2, which requires S. Otherwise the access is allowed.
- R12: A request made at the reserved privilege encoding 2 gives trap_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| csr_addr | input | 12 | CSR address of the request |
| priv | input | 2 | Current privilege level (U=0, S=1, M=3) |
| virt | input | 1 | Virtualization flag |
| stateen_present | input | 1 | State-enable control is implemented |
| m_ind_en | input | 1 | Indirect-access enable from the machine state-enable word |
| h_ind_en | input | 1 | Indirect-access enable from the hypervisor state-enable word |
| tgt_present | input | 1 | The current select value names an implemented target |
| allow | output | 1 | Registered verdict: access permitted |
| trap_illegal | output | 1 | Registered verdict: raise illegal-instruction trap |
| trap_virtual | output | 1 | Registered verdict: raise virtual-instruction trap |

## Verification
On every cycle the assertions check the following:
- the outputs are one-hot after each request and quiet after idle cycles;
- a machine-enable gate that is closed always yields an illegal verdict;
- virtual-supervisor copies accessed under virtualization trap as virtual once both gates are open;
- machine-class registers reached from M mode are allowed;
- the reserved privilege value is refused.

The check order itself can only be shown by the bench's scenarios and the full sweep. This covers the machine gate winning over the hypervisor gate, the virtualization rules winning over the missing-target rule, and the missing-target rule winning over the base privilege rule. The same holds for the inputs that must have no effect: the enable bits without state-enable control, and the virtualization flag in M mode.

// File: rtl/csrind_pkg.sv
package csrind_pkg;

  typedef enum logic [1:0] {
    PL_U    = 2'd0,
    PL_S    = 2'd1,
    PL_RSVD = 2'd2,
    PL_M    = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    CL_U  = 2'd0,
    CL_S  = 2'd1,
    CL_VS = 2'd2,
    CL_M  = 2'd3
  } cls_e;

  localparam int VD_W = 3;

  // one-hot verdict: bit0 allow, bit1 illegal, bit2 virtual
  typedef enum logic [VD_W-1:0] {
    VD_ALLOW = 3'b001,
    VD_ILL   = 3'b010,
    VD_VIRT  = 3'b100
  } verdict_e;

  typedef struct packed {
    logic       is_select;
    logic       below_m;
    logic       vs_class;
    logic [1:0] need_priv;
  } addr_info_t;

endpackage

// File: rtl/csrind_addr_decode.sv
module csrind_addr_decode
  import csrind_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CLS_LSB = 8,
  parameter int KEY_W   = ADDR_W - 2,
  parameter logic [KEY_W-1:0] SEL_KEY = 'h050
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_info_t        info
);

  localparam int CLS_MSB = CLS_LSB + 1;

  logic [KEY_W-1:0] key;
  cls_e             cls;

  assign key = {addr[ADDR_W-1:CLS_MSB+1], addr[CLS_LSB-1:0]};
  assign cls = cls_e'(addr[CLS_MSB:CLS_LSB]);

  always_comb begin
    info.is_select = (key == SEL_KEY);
    info.below_m   = (cls != CL_M);
    info.vs_class  = (cls == CL_VS);
    info.need_priv = (cls == CL_VS) ? 2'(PL_S) : 2'(cls);
  end

endmodule

// File: rtl/csrind_rule_eval.sv
module csrind_rule_eval
  import csrind_pkg::*;
(
  input  addr_info_t info,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       stateen_present,
  input  logic       m_ind_en,
  input  logic       h_ind_en,
  input  logic       tgt_present,
  output verdict_e   verdict
);

  logic below_m_priv;
  logic v_eff;
  logic gate_m_fail;
  logic gate_h_fail;
  logic vs_direct;
  logic vu_access;
  logic tgt_missing;
  logic priv_short;

  always_comb begin
    below_m_priv = (priv != 2'(PL_M));
    v_eff        = virt && below_m_priv;
    gate_m_fail  = info.below_m && stateen_present && below_m_priv && !m_ind_en;
    gate_h_fail  = info.below_m && stateen_present && v_eff && !h_ind_en;
    vs_direct    = info.below_m && v_eff && info.vs_class;
    vu_access    = info.below_m && v_eff && (priv == 2'(PL_U));
    tgt_missing  = !info.is_select && !tgt_present;
    priv_short   = (priv < info.need_priv);
  end

  // first failing rule decides
  always_comb begin
    if (priv == 2'(PL_RSVD))      verdict = VD_ILL;
    else if (gate_m_fail)          verdict = VD_ILL;
    else if (gate_h_fail)          verdict = VD_VIRT;
    else if (vs_direct)            verdict = VD_VIRT;
    else if (vu_access)            verdict = VD_VIRT;
    else if (tgt_missing)          verdict = VD_ILL;
    else if (priv_short)           verdict = VD_ILL;
    else                           verdict = VD_ALLOW;
  end

endmodule

// File: rtl/csrind_out_stage.sv
module csrind_out_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[k] <= 1'b0;
      else     q[k] <= valid & d[k];
    end
  end

endmodule

// File: rtl/csrind_perm_check.sv
module csrind_perm_check
  import csrind_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CLS_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              stateen_present,
  input  logic              m_ind_en,
  input  logic              h_ind_en,
  input  logic              tgt_present,
  output logic              allow,
  output logic              trap_illegal,
  output logic              trap_virtual
);

  addr_info_t     info;
  verdict_e       verdict;
  logic [VD_W-1:0] vq;

  csrind_addr_decode #(
    .ADDR_W (ADDR_W),
    .CLS_LSB(CLS_LSB)
  ) u_dec (
    .addr(csr_addr),
    .info(info)
  );

  csrind_rule_eval u_eval (
    .info           (info),
    .priv           (priv),
    .virt           (virt),
    .stateen_present(stateen_present),
    .m_ind_en       (m_ind_en),
    .h_ind_en       (h_ind_en),
    .tgt_present    (tgt_present),
    .verdict        (verdict)
  );

  csrind_out_stage #(.W(VD_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .valid(req_valid),
    .d    (verdict),
    .q    (vq)
  );

  assign allow        = vq[0];
  assign trap_illegal = vq[1];
  assign trap_virtual = vq[2];

endmodule

// File: rtl/csrind_perm_chk.sv
module csrind_perm_chk #(
  parameter int ADDR_W  = 12,
  parameter int CLS_LSB = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [1:0]        priv,
  input logic              virt,
  input logic              stateen_present,
  input logic              m_ind_en,
  input logic              h_ind_en,
  input logic              tgt_present,
  input logic              allow,
  input logic              trap_illegal,
  input logic              trap_virtual
);

  logic [1:0] cls;
  assign cls = csr_addr[CLS_LSB+1:CLS_LSB];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(allow || trap_illegal || trap_virtual));

  // R2
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> $countones({allow, trap_illegal, trap_virtual}) == 1);

  // R2
  never_two_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({allow, trap_illegal, trap_virtual}));

  // R3
  m_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && stateen_present && !m_ind_en && priv != 2'd3 && cls != 2'd3)
    |=> trap_illegal);

  // R5
  vs_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && virt && priv == 2'd1 && cls == 2'd2 &&
     (!stateen_present || (m_ind_en && h_ind_en)))
    |=> trap_virtual);

  // R8
  mclass_allow_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv == 2'd3 && cls == 2'd3 && tgt_present) |=> allow);

  // R12
  rsvd_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv == 2'd2) |=> trap_illegal);

endmodule

bind csrind_perm_check csrind_perm_chk #(
  .ADDR_W (ADDR_W),
  .CLS_LSB(CLS_LSB)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .csr_addr       (csr_addr),
  .priv           (priv),
  .virt           (virt),
  .stateen_present(stateen_present),
  .m_ind_en       (m_ind_en),
  .h_ind_en       (h_ind_en),
  .tgt_present    (tgt_present),
  .allow          (allow),
  .trap_illegal   (trap_illegal),
  .trap_virtual   (trap_virtual)
);

// File: tb/sim_csrind_perm_check.sv
module sim_csrind_perm_check;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] E_ALLOW = 3'b001;
  localparam logic [2:0] E_ILL   = 3'b010;
  localparam logic [2:0] E_VIRT  = 3'b100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  priv = '0;
  logic        virt = 1'b0;
  logic        stateen_present = 1'b0;
  logic        m_ind_en = 1'b0;
  logic        h_ind_en = 1'b0;
  logic        tgt_present = 1'b0;
  logic        allow, trap_illegal, trap_virtual;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csrind_perm_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .csr_addr(csr_addr),
    .priv(priv), .virt(virt), .stateen_present(stateen_present),
    .m_ind_en(m_ind_en), .h_ind_en(h_ind_en), .tgt_present(tgt_present),
    .allow(allow), .trap_illegal(trap_illegal), .trap_virtual(trap_virtual)
  );

  function automatic logic [11:0] mk_addr(input logic [1:0] cls, input logic sel,
                                           input logic [1:0] win);
    logic [7:0] lo;
    case (win)
      2'd0: lo = 8'h51;
      2'd1: lo = 8'h52;
      2'd2: lo = 8'h55;
      default: lo = 8'h57;
    endcase
    return {2'b00, cls, sel ? 8'h50 : lo};
  endfunction

  // model written from the requirement list
  function automatic logic [2:0] expect_of(input logic [1:0] cls, input logic sel,
      input logic [1:0] p, input logic v, input logic sp, input logic me,
      input logic he, input logic tp);
    logic       low, ve;
    logic [1:0] need;
    low  = (cls != 2'd3);
    ve   = v && (p != 2'd3);
    need = (cls == 2'd2) ? 2'd1 : cls;
    if (p == 2'd2)                         return E_ILL;   // R12
    if (low && sp && p != 2'd3 && !me)     return E_ILL;   // R3
    if (low && sp && ve && !he)            return E_VIRT;  // R4
    if (low && ve && cls == 2'd2)          return E_VIRT;  // R5
    if (low && ve && p == 2'd0)            return E_VIRT;  // R6
    if (!sel && !tp)                       return E_ILL;   // R7
    if (p < need)                          return E_ILL;   // R11
    return E_ALLOW;
  endfunction

  task automatic check_out(input logic [2:0] exp, input string req);
    logic [2:0] got;
    got = {trap_virtual, trap_illegal, allow};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b (virt,ill,allow) addr=%h priv=%0d v=%0d",
               req, got, exp, csr_addr, priv, virt);
    end
  endtask

  task automatic do_req(input logic [11:0] a, input logic [1:0] p, input logic v,
      input logic sp, input logic me, input logic he, input logic tp,
      input logic [2:0] exp, input string req);
    @(negedge clk);
    csr_addr = a; priv = p; virt = v; stateen_present = sp;
    m_ind_en = me; h_ind_en = he; tgt_present = tp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(exp, req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_out(3'b000, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check_out(3'b000, "R1 idle");
  endtask

  task automatic t_mgate;
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, E_ILL, "R3 S sel");
    do_req(mk_addr(2'd2, 1'b0, 2'd1), 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, E_ILL, "R3 over R4");
    @(negedge clk);
    check_out(3'b000, "R1 after request");
  endtask

  task automatic t_hgate;
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, E_VIRT, "R4 VS sel");
    do_req(mk_addr(2'd1, 1'b0, 2'd2), 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, E_VIRT, "R4 over R7");
  endtask

  task automatic t_vs_copy;
    do_req(mk_addr(2'd2, 1'b1, 2'd0), 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, E_VIRT, "R5 vs sel");
    do_req(mk_addr(2'd2, 1'b0, 2'd3), 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, E_VIRT, "R5 over R7");
    do_req(mk_addr(2'd2, 1'b1, 2'd0), 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, E_ALLOW, "R5 HS ok");
  endtask

  task automatic t_vu;
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, E_VIRT, "R6 VU sel");
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, E_ALLOW, "R6 VS sel ok");
  endtask

  task automatic t_unimpl;
    do_req(mk_addr(2'd1, 1'b0, 2'd0), 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, E_ILL, "R7 V=1 window");
    do_req(mk_addr(2'd1, 1'b0, 2'd1), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, E_ILL, "R7 V=0 window");
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, E_ALLOW, "R7 sel ignores flag");
  endtask

  task automatic t_mclass;
    do_req(mk_addr(2'd3, 1'b0, 2'd2), 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, E_ALLOW, "R8 M window");
    do_req(mk_addr(2'd3, 1'b0, 2'd2), 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, E_ILL, "R8 from VS");
  endtask

  task automatic t_mmode;
    do_req(mk_addr(2'd2, 1'b0, 2'd0), 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, E_ALLOW, "R9 M bypass");
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, E_ALLOW, "R9 M virt ignored");
  endtask

  task automatic t_no_stateen;
    do_req(mk_addr(2'd1, 1'b0, 2'd3), 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, E_ALLOW, "R10 enables ignored");
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, E_ALLOW, "R10 HS");
  endtask

  task automatic t_base;
    do_req(mk_addr(2'd1, 1'b1, 2'd0), 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, E_ILL, "R11 U to S");
    do_req(mk_addr(2'd2, 1'b1, 2'd0), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, E_ILL, "R11 U to VS");
    do_req(mk_addr(2'd0, 1'b1, 2'd0), 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, E_ALLOW, "R11 U class");
  endtask

  task automatic t_rsvd;
    do_req(mk_addr(2'd0, 1'b1, 2'd0), 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, E_ILL, "R12 reserved");
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 64; k++) begin
          logic v, sp, me, he, tp, sel;
          {v, sp, me, he, tp, sel} = 6'(k);
          do_req(mk_addr(2'(c), sel, 2'(k % 4)), 2'(p), v, sp, me, he, tp,
                 expect_of(2'(c), sel, 2'(p), v, sp, me, he, tp), "R2 sweep");
        end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mgate();
    t_hgate();
    t_vs_copy();
    t_vu();
    t_unimpl();
    t_mclass();
    t_mmode();
    t_no_stateen();
    t_base();
    t_rsvd();
    t_sweep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule